// File: doc/BRIEF.md
# Serial LED Shift Driver

This block feeds a chain of external 8-bit shift registers, up to three of them for 24 lamp outputs. It uses three wires: serial data, a shift clock and a store strobe. Software reaches it through a small word-addressed register bus. Five registers are decoded: two control words, two data words and a scratch access word. The low byte of the outgoing word can be shared with hardware. Per-bit ownership fields let a DSL status pair and two PHY status pairs replace chosen low bits of the CPU data word whenever a frame is built.

A frame starts in one of two ways. Software can request one by writing the update bit of the first control word. The block can also refresh the chain on its own, from a rate timer that runs while any bit is hardware-owned and an update source is selected. Each frame shifts the enabled width most significant bit first. The strobe is then raised for one shift-clock period so the external registers transfer their contents to their outputs.

Top module: `led_shift_drv`

## Requirements
- R1: After reset, offset 0x00 reads 0x8000_0000 and offsets 0x04, 0x08, 0x0C and 0x10 read zero. The shift clock sits at its idle level (low, because bit 26 of 0x00 is 0), and the data out, strobe and busy outputs are all low.
- R2: Offsets 0x04, 0x08, 0x0C and 0x10 read back the last 32-bit value written to them. Any other offset reads zero and ignores writes.
- R3: Writing bit 31 of 0x00 as 1 requests a frame, and that bit reads 1 until the frame starts, then reads 0. Writing the bit as 0 leaves a pending request in place and starts nothing. A request waits for as long as no group is enabled; this is also the case after reset.
- R4: Bits 2:0 of 0x04 enable the 8-bit groups. A frame carries 8 times (index of the highest set bit + 1) bits, taken from the low bits of the composed word. No frame starts while all three bits are 0.
- R5: Bits go out most significant first. Each bit lasts 2*SHIFT_DIV clocks. Bit 26 of 0x00 selects the sampling edge: 1 means falling, 0 means rising. The shift clock idles at the opposite level (high for falling, low for rising). It reaches the sampling edge halfway through each bit, and data changes only while the clock is at its idle level.
- R6: After the last bit, the strobe is high for 2*SHIFT_DIV clocks while the shift clock stays idle. Busy stays high from the first bit to the end of the strobe.
- R7: A request that arrives while busy is held, and its frame starts exactly one idle clock after busy falls.
- R8: Bits 25:24 of 0x00 take output bits 1:0 from the DSL status input. Bits 28:27 of 0x00 take output bits 3:2 from PHY1 status. Bits 16:15 of 0x04 take output bits 6:5 from PHY2 status. Each owned bit carries the status value present on the clock that starts the frame. Every other bit comes from 0x08.
- R9: When any ownership bit is set and bits 31:30 of 0x04 are nonzero, a frame is requested every CLK_HZ/f clocks. The rate f is 2, 4, 8 or 10 for bits 24:23 of 0x00 equal to 00, 01, 10 or 11. When the condition is false, the timer stays cleared and no periodic frames occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System and bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | 5 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| dsl_led_i | input | 2 | DSL status for output bits 1:0 |
| phy1_led_i | input | 2 | PHY1 status for output bits 3:2 |
| phy2_led_i | input | 2 | PHY2 status for output bits 6:5 |
| sck_o | output | 1 | Shift clock to the register chain |
| sdo_o | output | 1 | Serial data to the register chain |
| stb_o | output | 1 | Store strobe to the register chain |
| busy_o | output | 1 | Frame or strobe in progress |

## Verification
The bench builds the block with CLK_HZ = 4000 and SHIFT_DIV = 2. Under those values, each bit lasts four clocks and the four refresh periods shrink to 2000, 1000, 500 and 400 clocks. That keeps every rate, a full 24-bit frame, and back-to-back requests short enough to measure to the exact cycle in one run. A per-clock model predicts the shift clock, data, strobe and busy levels from the writes and status values alone.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int N_GRP  = 3;
  localparam int GRP_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL0 = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL1 = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DATA0 = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_DATA1 = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_ACC   = 5'h10;

  localparam int BIT_REQ  = 31;
  localparam int DSL_POS  = 0;
  localparam int PHY1_POS = 2;
  localparam int PHY2_POS = 5;

  typedef struct packed {
    logic             falling;
    logic [1:0]       rate;
    logic [1:0]       dsl;
    logic [1:0]       phy1;
    logic [1:0]       phy2;
    logic [1:0]       upd_src;
    logic [N_GRP-1:0] groups;
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_STROBE} shf_state_e;
endpackage

// File: rtl/lsd_regs.sv
module lsd_regs
  import led_shift_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_start_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sw_req_o
);
  logic [DATA_W-2:0] ctrl0_q;
  logic              req_q;
  logic [DATA_W-1:0] ctrl1_q, data0_q, data1_q, acc_q;
  logic              wr_c0;

  assign wr_c0 = we_i && (addr_i == OFF_CTRL0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q <= '0;
      req_q   <= 1'b1;
      ctrl1_q <= '0;
      data0_q <= '0;
      data1_q <= '0;
      acc_q   <= '0;
    end else begin
      if (frame_start_i) req_q <= 1'b0;
      if (wr_c0) begin
        ctrl0_q <= wdata_i[DATA_W-2:0];
        if (wdata_i[BIT_REQ]) req_q <= 1'b1;
      end
      if (we_i && addr_i == OFF_CTRL1) ctrl1_q <= wdata_i;
      if (we_i && addr_i == OFF_DATA0) data0_q <= wdata_i;
      if (we_i && addr_i == OFF_DATA1) data1_q <= wdata_i;
      if (we_i && addr_i == OFF_ACC)   acc_q   <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      OFF_CTRL0: rdata_o = {req_q, ctrl0_q};
      OFF_CTRL1: rdata_o = ctrl1_q;
      OFF_DATA0: rdata_o = data0_q;
      OFF_DATA1: rdata_o = data1_q;
      OFF_ACC:   rdata_o = acc_q;
      default:   rdata_o = '0;
    endcase
  end

  assign cfg_o.falling = ctrl0_q[26];
  assign cfg_o.rate    = ctrl0_q[24:23];
  assign cfg_o.dsl     = ctrl0_q[25:24];
  assign cfg_o.phy1    = ctrl0_q[28:27];
  assign cfg_o.phy2    = ctrl1_q[16:15];
  assign cfg_o.upd_src = ctrl1_q[31:30];
  assign cfg_o.groups  = ctrl1_q[N_GRP-1:0];
  assign data_o        = data0_q;
  assign sw_req_o      = req_q;

  assert_req_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_c0 && wdata_i[BIT_REQ] |=> sw_req_o);
  assert_req_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !(wr_c0 && wdata_i[BIT_REQ]) |=> !sw_req_o);
endmodule

// File: rtl/lsd_rate_tmr.sv
module lsd_rate_tmr #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] rate_i,
  output logic       fire_o
);
  localparam int unsigned MAX_DIV = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;
  localparam int          CNT_W   = $clog2(MAX_DIV + 1);

  function automatic logic [CNT_W-1:0] term_of(input logic [1:0] r);
    int unsigned d;
    case (r)
      2'd0:    d = CLK_HZ / 2;
      2'd1:    d = CLK_HZ / 4;
      2'd2:    d = CLK_HZ / 8;
      default: d = CLK_HZ / 10;
    endcase
    if (d < 1) d = 1;
    return CNT_W'(d - 1);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term = term_of(rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else if (cnt_q >= term) begin
      cnt_q  <= '0;
      fire_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      fire_o <= 1'b0;
    end
  end

  assert_fire_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(en_i));
endmodule

// File: rtl/lsd_frame_shift.sv
module lsd_frame_shift
  import led_shift_pkg::*;
#(
  parameter int SHIFT_DIV = 4,
  parameter int MAX_BITS  = 24
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [MAX_BITS-1:0]           word_i,
  input  logic [$clog2(MAX_BITS+1)-1:0] nbits_i,
  input  logic                          falling_i,
  output logic                          sck_o,
  output logic                          sdo_o,
  output logic                          stb_o,
  output logic                          busy_o
);
  localparam int IDX_W = $clog2(MAX_BITS);
  localparam int CNT_W = (2 * SHIFT_DIV > 1) ? $clog2(2 * SHIFT_DIV) : 1;
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(SHIFT_DIV - 1);
  localparam logic [CNT_W-1:0] STB_END  = CNT_W'(2 * SHIFT_DIV - 1);

  shf_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                half_q;
  logic [IDX_W-1:0]    idx_q;
  logic [MAX_BITS-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      idx_q   <= '0;
      word_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SHIFT;
          word_q  <= word_i;
          idx_q   <= IDX_W'(nbits_i - 1'b1);
          cnt_q   <= '0;
          half_q  <= 1'b0;
        end
        ST_SHIFT: begin
          if (cnt_q == HALF_END) begin
            cnt_q <= '0;
            if (half_q) begin
              half_q <= 1'b0;
              if (idx_q == '0) state_q <= ST_STROBE;
              else             idx_q   <= idx_q - 1'b1;
            end else begin
              half_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt_q == STB_END) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // sampling edge falls at mid-bit; the edge back to idle is where data moves
  assign sck_o  = falling_i ^ ((state_q == ST_SHIFT) && half_q);
  assign sdo_o  = (state_q == ST_SHIFT) ? word_q[idx_q] : 1'b0;
  assign stb_o  = (state_q == ST_STROBE);
  assign busy_o = (state_q != ST_IDLE);

  assert_start_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  assert_data_on_idle_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && (sdo_o != $past(sdo_o)) |-> sck_o == falling_i);
  assert_strobe_closes_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(stb_o));
endmodule

// File: rtl/led_shift_drv.sv
module led_shift_drv
  import led_shift_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int          SHIFT_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [1:0]        dsl_led_i,
  input  logic [1:0]        phy1_led_i,
  input  logic [1:0]        phy2_led_i,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              stb_o,
  output logic              busy_o
);
  localparam int MAX_BITS = N_GRP * GRP_W;
  localparam int NB_W     = $clog2(MAX_BITS + 1);

  cfg_t                cfg;
  logic [DATA_W-1:0]   data0;
  logic                sw_req, fire, tick_pend_q, start, auto_en;
  logic [MAX_BITS-1:0] hw_mask, hw_val, word;
  logic [NB_W-1:0]     nbits;

  lsd_regs u_regs (
    .clk_i, .rst_ni,
    .we_i          (bus_we_i),
    .addr_i        (bus_addr_i),
    .wdata_i       (bus_wdata_i),
    .rdata_o       (bus_rdata_o),
    .frame_start_i (start),
    .cfg_o         (cfg),
    .data_o        (data0),
    .sw_req_o      (sw_req)
  );

  always_comb begin
    hw_mask = '0;
    hw_val  = '0;
    hw_mask[DSL_POS+:2]  = cfg.dsl;
    hw_mask[PHY1_POS+:2] = cfg.phy1;
    hw_mask[PHY2_POS+:2] = cfg.phy2;
    hw_val[DSL_POS+:2]   = dsl_led_i;
    hw_val[PHY1_POS+:2]  = phy1_led_i;
    hw_val[PHY2_POS+:2]  = phy2_led_i;
  end

  assign word = (data0[MAX_BITS-1:0] & ~hw_mask) | (hw_val & hw_mask);

  always_comb begin
    nbits = '0;
    for (int g = 0; g < N_GRP; g++)
      if (cfg.groups[g]) nbits = NB_W'((g + 1) * GRP_W);
  end

  assign auto_en = (|hw_mask) && (|cfg.upd_src);

  lsd_rate_tmr #(.CLK_HZ(CLK_HZ)) u_tmr (
    .clk_i, .rst_ni,
    .en_i   (auto_en),
    .rate_i (cfg.rate),
    .fire_o (fire)
  );

  assign start = !busy_o && (sw_req || tick_pend_q) && (|cfg.groups);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_pend_q <= 1'b0;
    else         tick_pend_q <= fire | (tick_pend_q & ~start);
  end

  lsd_frame_shift #(.SHIFT_DIV(SHIFT_DIV), .MAX_BITS(MAX_BITS)) u_shift (
    .clk_i, .rst_ni,
    .start_i   (start),
    .word_i    (word),
    .nbits_i   (nbits),
    .falling_i (cfg.falling),
    .sck_o, .sdo_o, .stb_o, .busy_o
  );

  assert_frame_needs_group_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(|cfg.groups));
  assert_tick_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> tick_pend_q);
endmodule

// File: tb/led_shift_drv_bench.sv
module led_shift_drv_bench;
  localparam int unsigned CLK_HZ_TB = 4000;
  localparam int SD = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  dsl_i = '0, phy1_i = '0, phy2_i = '0;
  logic        sck, sdo, stb, busy;

  always #2 clk = ~clk;

  led_shift_drv #(.CLK_HZ(CLK_HZ_TB), .SHIFT_DIV(SD)) u_led_shift_drv (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .dsl_led_i(dsl_i),
    .phy1_led_i(phy1_i), .phy2_led_i(phy2_i), .sck_o(sck), .sdo_o(sdo),
    .stb_o(stb), .busy_o(busy)
  );

  int    n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [30:0] m_c0 = '0;
  logic        m_req = 1'b1;
  logic [31:0] m_c1 = '0, m_d0 = '0;
  logic        m_tpend = 1'b0, m_fire = 1'b0;
  int unsigned m_cnt = 0;
  logic [2:0]  m_q[$];   // {stb, sdo, sck} per clock

  function automatic int unsigned m_period(input logic [1:0] r);
    case (r)
      2'd0: return CLK_HZ_TB / 2;
      2'd1: return CLK_HZ_TB / 4;
      2'd2: return CLK_HZ_TB / 8;
      default: return CLK_HZ_TB / 10;
    endcase
  endfunction

  function automatic logic [23:0] owned(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
    return 24'(a) | (24'(b) << 2) | (24'(c) << 5);
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic st, en, nf, idl;
    logic [23:0] msk, w;
    int nb;
    if (!rst_n) begin
      m_c0 = '0; m_req = 1'b1; m_c1 = '0; m_d0 = '0;
      m_tpend = 1'b0; m_fire = 1'b0; m_cnt = 0; m_q.delete();
    end else begin
      msk = owned(m_c0[25:24], m_c0[28:27], m_c1[16:15]);
      nb  = m_c1[2] ? 24 : m_c1[1] ? 16 : m_c1[0] ? 8 : 0;
      idl = m_c0[26];
      st  = (m_q.size() == 0) && (m_req || m_tpend) && (nb != 0);
      if (m_q.size() != 0) void'(m_q.pop_front());
      if (st) begin
        w = (m_d0[23:0] & ~msk) | (owned(dsl_i, phy1_i, phy2_i) & msk);
        for (int i = nb - 1; i >= 0; i--)
          for (int c = 0; c < 2 * SD; c++)
            m_q.push_back({1'b0, w[i], idl ^ (c >= SD)});
        for (int c = 0; c < 2 * SD; c++) m_q.push_back({1'b1, 1'b0, idl});
        m_req = 1'b0;
      end
      en = (msk != 0) && (m_c1[31:30] != 0);
      nf = 1'b0;
      if (!en) m_cnt = 0;
      else if (m_cnt >= m_period(m_c0[24:23]) - 1) begin m_cnt = 0; nf = 1'b1; end
      else m_cnt++;
      m_tpend = m_fire | (m_tpend & !st);
      m_fire  = nf;
      if (we && addr == 5'h00) begin m_c0 = wdata[30:0]; if (wdata[31]) m_req = 1'b1; end
      if (we && addr == 5'h04) m_c1 = wdata;
      if (we && addr == 5'h08) m_d0 = wdata;
    end
  end

  always @(negedge clk) if (rst_n) begin : cmp
    logic [2:0] e;
    logic eb;
    if (m_q.size() != 0) begin e = m_q[0]; eb = 1'b1; end
    else begin e = {2'b00, m_c0[26]}; eb = 1'b0; end
    check(sck == e[0], "R5 shift clock", sck, e[0]);
    check(sdo == e[1], "R8 serial data", sdo, e[1]);
    check(stb == e[2], "R6 strobe", stb, e[2]);
    check(busy == eb, "R6 busy", busy, eb);
  end

  // ---------------- bus and observation tasks ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic wait_rise(output longint t);
    @(negedge clk);
    while (busy) @(negedge clk);
    while (!busy) @(negedge clk);
    t = cyc;
  endtask

  task automatic capture(input int n, output logic [23:0] w);
    w = '0;
    @(negedge clk);
    while (!busy) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      w[i] = sdo;
      repeat (2 * SD) @(negedge clk);
    end
  endtask

  task automatic frame_len(output int n, output int s);
    n = 0; s = 0;
    @(negedge clk);
    while (!busy) @(negedge clk);
    while (busy) begin n++; if (stb) s++; @(negedge clk); end
  endtask

  task automatic count_rises(input int n, output int r);
    logic prev;
    r = 0; prev = busy;
    repeat (n) begin
      @(negedge clk);
      if (busy && !prev) r++;
      prev = busy;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [23:0] w;
    longint t0, t1;
    int n, s, k;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(sck == 1'b0 && sdo == 1'b0 && stb == 1'b0 && busy == 1'b0, "R1 outputs", {sck, sdo, stb, busy}, 0);
    rd(5'h00, r); check(r == 32'h8000_0000, "R1 ctrl0", r, 32'h8000_0000);
    rd(5'h04, r); check(r == 0, "R1 ctrl1", r, 0);
    rd(5'h08, r); check(r == 0, "R1 data0", r, 0);
    rd(5'h0C, r); check(r == 0, "R1 data1", r, 0);
    rd(5'h10, r); check(r == 0, "R1 access", r, 0);

    // R3 request waits with no group enabled
    count_rises(20, k); check(k == 0, "R3 held without groups", k, 0);

    // R2 register map
    wr(5'h0C, 32'h1234_5678); wr(5'h10, 32'hCAFE_F00D); wr(5'h08, 32'h003C_96A5);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h0C, r); check(r == 32'h1234_5678, "R2 data1", r, 32'h1234_5678);
    rd(5'h10, r); check(r == 32'hCAFE_F00D, "R2 access", r, 32'hCAFE_F00D);
    rd(5'h08, r); check(r == 32'h003C_96A5, "R2 data0", r, 32'h003C_96A5);
    rd(5'h14, r); check(r == 0, "R2 unmapped", r, 0);
    rd(5'h00, r); check(r == 32'h8000_0000, "R3 still pending", r, 32'h8000_0000);

    // R3 enabling group 0 services the reset request, MSB first (R5)
    wr(5'h04, 32'h1);
    capture(8, w); check(w == 24'hA5, "R5 msb first", w, 24'hA5);
    rd(5'h00, r); check(r == 0, "R3 cleared after start", r, 0);
    wait_idle();

    // R3 writing 0 does not request
    wr(5'h00, 32'h0);
    count_rises(60, k); check(k == 0, "R3 zero write ignored", k, 0);

    // R4 frame widths
    wr(5'h04, 32'h4); wr(5'h00, 32'h8000_0000);
    frame_len(n, s); check(n == 24 * 2 * SD + 2 * SD, "R4 group2 length", n, 24 * 2 * SD + 2 * SD);
    wr(5'h04, 32'h2); wr(5'h00, 32'h8000_0000);
    frame_len(n, s); check(n == 16 * 2 * SD + 2 * SD, "R4 group1 length", n, 16 * 2 * SD + 2 * SD);
    check(s == 2 * SD, "R6 strobe width", s, 2 * SD);
    wr(5'h04, 32'h7); wr(5'h00, 32'h8000_0000);
    capture(24, w); check(w == 24'h3C96A5, "R4 24-bit word", w, 24'h3C96A5);
    wait_idle();

    // R5 falling-edge sampling, clock idles high
    wr(5'h04, 32'h1); wr(5'h00, 32'h0400_0000);
    @(negedge clk); check(sck == 1'b1, "R5 idle high", sck, 1);
    wr(5'h00, 32'h8400_0000);
    capture(8, w); check(w == 24'hA5, "R5 falling frame", w, 24'hA5);
    wait_idle(); check(sck == 1'b1, "R5 idle after frame", sck, 1);
    wr(5'h00, 32'h0);

    // R7 request during a frame
    wr(5'h00, 32'h8000_0000);
    wait_rise(t0);
    repeat (5) @(negedge clk);
    wr(5'h00, 32'h8000_0000);
    while (busy) @(negedge clk);
    k = 0;
    while (!busy) begin k++; @(negedge clk); end
    check(k == 1, "R7 one idle clock", k, 1);
    wait_idle();

    // R8 hardware-owned bits
    dsl_i = 2'b10; phy1_i = 2'b01; phy2_i = 2'b11;
    wr(5'h04, 32'h0001_8001);
    wr(5'h00, 32'h9B00_0000);
    capture(8, w);
    check(w == ((24'hA5 & ~24'h6F) | (24'h66 & 24'h6F)), "R8 merge a", w, 24'hE6);
    wait_idle();
    dsl_i = 2'b01; phy1_i = 2'b10; phy2_i = 2'b00;
    wr(5'h00, 32'h9B00_0000);
    capture(8, w); check(w == 24'h89, "R8 merge b", w, 24'h89);
    wait_idle();
    wr(5'h00, 32'h0);

    // R9 periodic refresh
    wr(5'h04, 32'h8000_0001);
    wr(5'h00, 32'h0180_0000);
    wait_rise(t0); wait_rise(t0); wait_rise(t1);
    check(t1 - t0 == 400, "R9 10 Hz period", t1 - t0, 400);
    wr(5'h00, 32'h0100_0000);
    wait_rise(t0); wait_rise(t0); wait_rise(t1);
    check(t1 - t0 == 500, "R9 8 Hz period", t1 - t0, 500);
    wr(5'h00, 32'h0280_0000);
    wait_rise(t0); wait_rise(t0); wait_rise(t1);
    check(t1 - t0 == 1000, "R9 4 Hz period", t1 - t0, 1000);
    wr(5'h00, 32'h0200_0000);
    wait_rise(t0); wait_rise(t0); wait_rise(t1);
    check(t1 - t0 == 2000, "R9 2 Hz period", t1 - t0, 2000);
    wr(5'h04, 32'h0000_0001);
    repeat (60) @(negedge clk);
    count_rises(2100, k); check(k == 0, "R9 source off", k, 0);

    finish_run();
  end
endmodule